// File: doc/BRIEF.md
# Context Program Sequencer

This block is a small microcoded engine that runs a save/restore routine for a graphics engine's working state. The routine sits in a 256-word instruction store of 24-bit words, which is loaded through a write port while the engine is idle. A start pulse runs the routine from address 0. The routine tests, waits on and writes single bits of a 128-entry flag file. It loads a 20-bit state-size register and issues block-transfer commands. A transfer command names a starting register word offset and a word count, and carries a direction bit: save (state to buffer) or load (buffer to state).

The host posts save and load requests as pulses, which latch into two pending flags. The auto-save and auto-load requests, the engine busy status and a constant-one flag are wired straight into the flag file and cannot be written. Each transfer is presented on a command port and held until an external mover acknowledges it. Three context-pointer operations are reported as one-cycle pulses with their code. The end instruction returns the engine to idle with a done pulse. An unknown instruction halts the engine with a sticky error flag.

Top module: `ctx_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `error`, `xferValid` and `ctxOpValid` are 0, `stateSize` is 0 and all writable flags are 0.
- R2: A `start` pulse while idle begins execution at address 0, and `busy` stays 1 until the program ends or halts.
- R3: Opcode 4 (bits 23:20) is a conditional branch to the address in bits 15:8 on the flag indexed by bits 6:0. The branch is taken when the flag is 1 if bit 7 is 0, and when the flag is 0 if bit 7 is 1. Otherwise execution falls through to the next address.
- R4: Opcode 5 stalls at its own address until the flag indexed by bits 6:0 equals bit 7.
- R5: Opcode 7 writes bit 7 into the flag indexed by bits 6:0. Flags 96 (engine busy input), 100 (auto-save input), 101 (auto-load input) and 104 (constant 1) always show their source, and writes to them have no effect.
- R6: Opcode 2 loads bits 19:0 into `stateSize`, and `stateSize` does not change while the engine is not busy.
- R7: Opcode 1 issues a transfer with count = bits 19:14 and register = bits 13:0. Its direction is flag 0 (1 = save, 0 = load). `xferValid` and the command fields stay stable until `xferAck`, and execution does not advance before then.
- R8: Opcode 6 with low byte 0x07, 0x09 or 0x0a pulses `ctxOpValid` for one cycle with that byte on `ctxOpCode`.
- R9: Opcode 6 with low byte 0x0e ends the program: `done` pulses for one cycle and the engine is idle in the same cycle.
- R10: `hostSaveReq` sets flag 5 and `hostLoadReq` sets flag 6. These flags remain set until an opcode 7 instruction clears them.
- R11: Opcode 0, 3 or 8 to 15, or opcode 6 with any other low byte, halts the engine and sets `error`. `error` stays set and `start` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progWe | input | 1 | Instruction store write enable |
| progAddr | input | 8 | Instruction store write address |
| progData | input | 24 | Instruction store write data |
| start | input | 1 | Run program from address 0 |
| hostSaveReq | input | 1 | Pulse: post a host save request (flag 5) |
| hostLoadReq | input | 1 | Pulse: post a host load request (flag 6) |
| autoSave | input | 1 | Auto-save request level (flag 100) |
| autoLoad | input | 1 | Auto-load request level (flag 101) |
| gfxBusy | input | 1 | Engine busy status level (flag 96) |
| xferValid | output | 1 | Transfer command pending |
| xferReg | output | 14 | Transfer start register word offset |
| xferCount | output | 6 | Transfer word count |
| xferSave | output | 1 | Transfer direction, 1 = save |
| xferAck | input | 1 | Transfer command accepted |
| ctxOpValid | output | 1 | Context-pointer operation pulse |
| ctxOpCode | output | 8 | Context-pointer operation code |
| stateSize | output | 20 | State-size register |
| busy | output | 1 | Program running |
| done | output | 1 | Program-end pulse |
| error | output | 1 | Sticky illegal-instruction flag |

## Verification
The checker watches four things on every cycle. A pending transfer holds its fields until accepted, and `done` is a lone pulse that comes with idle. The error flag stays set and keeps the engine silent, and `stateSize` only moves while running. Branch polarity, the flag indexing and the stall of the wait instruction can only be shown by the bench's programs, which observe the transfer and operation codes the program reaches. The same holds for the protected flags, the clearing of pending requests and the restart from address 0.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;
  localparam int IMEM_DEPTH = 256;
  localparam int ADDR_W     = $clog2(IMEM_DEPTH);
  localparam int INSTR_W    = 24;
  localparam int FLAG_N     = 128;
  localparam int FLAG_IDX_W = $clog2(FLAG_N);
  localparam int SIZE_W     = 20;
  localparam int XREG_W     = 14;
  localparam int XCNT_W     = 6;
  localparam int OPC_W      = 4;
  localparam int SUB_W      = 8;

  localparam logic [OPC_W-1:0] OPC_XFER = 4'h1;
  localparam logic [OPC_W-1:0] OPC_SIZE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_BRA  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_WAIT = 4'h5;
  localparam logic [OPC_W-1:0] OPC_MISC = 4'h6;
  localparam logic [OPC_W-1:0] OPC_SET  = 4'h7;

  localparam logic [SUB_W-1:0] SUB_TO_SWAP = 8'h07;
  localparam logic [SUB_W-1:0] SUB_TO_CUR  = 8'h09;
  localparam logic [SUB_W-1:0] SUB_CTX_PTR = 8'h0a;
  localparam logic [SUB_W-1:0] SUB_END     = 8'h0e;

  localparam int FLG_DIR   = 0;
  localparam int FLG_USAVE = 5;
  localparam int FLG_ULOAD = 6;
  localparam int FLG_BUSY  = 96;
  localparam int FLG_ASAVE = 100;
  localparam int FLG_ALOAD = 101;
  localparam int FLG_ONE   = 104;

  typedef struct packed {
    logic flagWr;
    logic sizeLd;
    logic xferLd;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_XFER = 2'd2,
    ST_HALT = 2'd3
  } seqState_t;
endpackage

// File: rtl/ctxseq_datapath.sv
module ctxseq_datapath
  import ctxseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               progWe,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic [ADDR_W-1:0]  pc,
  input  seqStrobe_t         strobe,
  input  logic               hostSaveReq,
  input  logic               hostLoadReq,
  input  logic               autoSave,
  input  logic               autoLoad,
  input  logic               gfxBusy,
  output logic [OPC_W-1:0]   opCode,
  output logic [ADDR_W-1:0]  brTarget,
  output logic [SUB_W-1:0]   subCode,
  output logic               flagBit,
  output logic [XREG_W-1:0]  xferReg,
  output logic [XCNT_W-1:0]  xferCount,
  output logic               xferSave,
  output logic [SIZE_W-1:0]  stateSize
);
  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [INSTR_W-1:0] instr;
  logic [FLAG_N-1:0]  flagEff;
  logic [FLAG_IDX_W-1:0] selIdx;
  logic               wrVal;

  always_ff @(posedge clk) begin
    if (progWe) imem[progAddr] <= progData;
  end

  assign instr    = imem[pc];
  assign opCode   = instr[INSTR_W-1 -: OPC_W];
  assign brTarget = instr[15:8];
  assign subCode  = instr[SUB_W-1:0];
  assign selIdx   = instr[FLAG_IDX_W-1:0];
  assign wrVal    = instr[7];

  // Flag file: protected entries are wires from their sources, the rest are storage bits.
  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
    if (gi == FLG_BUSY) begin : g_busy
      assign flagEff[gi] = gfxBusy;
    end else if (gi == FLG_ASAVE) begin : g_asave
      assign flagEff[gi] = autoSave;
    end else if (gi == FLG_ALOAD) begin : g_aload
      assign flagEff[gi] = autoLoad;
    end else if (gi == FLG_ONE) begin : g_one
      assign flagEff[gi] = 1'b1;
    end else begin : g_store
      logic bitQ;
      logic hostSet;
      if (gi == FLG_USAVE) begin : g_hs
        assign hostSet = hostSaveReq;
      end else if (gi == FLG_ULOAD) begin : g_hl
        assign hostSet = hostLoadReq;
      end else begin : g_nh
        assign hostSet = 1'b0;
      end
      always_ff @(posedge clk) begin
        if (!rstN) bitQ <= 1'b0;
        else if (strobe.flagWr && selIdx == FLAG_IDX_W'(gi)) bitQ <= wrVal;
        else if (hostSet) bitQ <= 1'b1;
      end
      assign flagEff[gi] = bitQ;
    end
  end

  assign flagBit = flagEff[selIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferReg   <= '0;
      xferCount <= '0;
      xferSave  <= 1'b0;
      stateSize <= '0;
    end else begin
      if (strobe.xferLd) begin
        xferReg   <= instr[XREG_W-1:0];
        xferCount <= instr[XREG_W +: XCNT_W];
        xferSave  <= flagEff[FLG_DIR];
      end
      if (strobe.sizeLd) stateSize <= instr[SIZE_W-1:0];
    end
  end
endmodule

// File: rtl/ctxseq_ctrl.sv
module ctxseq_ctrl
  import ctxseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              xferAck,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [SUB_W-1:0]  subCode,
  input  logic              flagBit,
  output logic [ADDR_W-1:0] pc,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              xferValid,
  output logic              ctxOpValid,
  output logic [SUB_W-1:0]  ctxOpCode
);
  seqState_t state, stateNext;
  logic [ADDR_W-1:0] pcNext, pcInc;
  logic doneNext, opNext, errSet, condBit;

  assign pcInc   = pc + 1'b1;
  assign condBit = subCode[7];

  always_comb begin
    stateNext = state;
    pcNext    = pc;
    strobe    = '0;
    doneNext  = 1'b0;
    opNext    = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext = ST_RUN;
          pcNext    = '0;
        end
      end
      ST_RUN: begin
        unique case (opCode)
          OPC_XFER: begin
            strobe.xferLd = 1'b1;
            stateNext     = ST_XFER;
          end
          OPC_SIZE: begin
            strobe.sizeLd = 1'b1;
            pcNext        = pcInc;
          end
          OPC_BRA:  pcNext = (flagBit != condBit) ? brTarget : pcInc;
          OPC_WAIT: pcNext = (flagBit == condBit) ? pcInc : pc;
          OPC_SET: begin
            strobe.flagWr = 1'b1;
            pcNext        = pcInc;
          end
          OPC_MISC: begin
            unique case (subCode)
              SUB_TO_SWAP, SUB_TO_CUR, SUB_CTX_PTR: begin
                opNext = 1'b1;
                pcNext = pcInc;
              end
              SUB_END: begin
                doneNext  = 1'b1;
                stateNext = ST_IDLE;
              end
              default: begin
                errSet    = 1'b1;
                stateNext = ST_HALT;
              end
            endcase
          end
          default: begin
            errSet    = 1'b1;
            stateNext = ST_HALT;
          end
        endcase
      end
      ST_XFER: begin
        if (xferAck) begin
          stateNext = ST_RUN;
          pcNext    = pcInc;
        end
      end
      ST_HALT: stateNext = ST_HALT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pc         <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
      ctxOpValid <= 1'b0;
      ctxOpCode  <= '0;
    end else begin
      state      <= stateNext;
      pc         <= pcNext;
      done       <= doneNext;
      ctxOpValid <= opNext;
      if (errSet) error <= 1'b1;
      if (opNext) ctxOpCode <= subCode;
    end
  end

  assign busy      = (state == ST_RUN) || (state == ST_XFER);
  assign xferValid = (state == ST_XFER);
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
  import ctxseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               progWe,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic               start,
  input  logic               hostSaveReq,
  input  logic               hostLoadReq,
  input  logic               autoSave,
  input  logic               autoLoad,
  input  logic               gfxBusy,
  output logic               xferValid,
  output logic [XREG_W-1:0]  xferReg,
  output logic [XCNT_W-1:0]  xferCount,
  output logic               xferSave,
  input  logic               xferAck,
  output logic               ctxOpValid,
  output logic [SUB_W-1:0]   ctxOpCode,
  output logic [SIZE_W-1:0]  stateSize,
  output logic               busy,
  output logic               done,
  output logic               error
);
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] pc, brTarget;
  logic [OPC_W-1:0]  opCode;
  logic [SUB_W-1:0]  subCode;
  logic              flagBit;

  ctxseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xferAck(xferAck),
    .opCode(opCode), .brTarget(brTarget), .subCode(subCode), .flagBit(flagBit),
    .pc(pc), .strobe(strobe), .busy(busy), .done(done), .error(error),
    .xferValid(xferValid), .ctxOpValid(ctxOpValid), .ctxOpCode(ctxOpCode)
  );

  ctxseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .pc(pc), .strobe(strobe), .hostSaveReq(hostSaveReq), .hostLoadReq(hostLoadReq),
    .autoSave(autoSave), .autoLoad(autoLoad), .gfxBusy(gfxBusy),
    .opCode(opCode), .brTarget(brTarget), .subCode(subCode), .flagBit(flagBit),
    .xferReg(xferReg), .xferCount(xferCount), .xferSave(xferSave), .stateSize(stateSize)
  );
endmodule

// File: rtl/ctxseq_checker.sv
module ctxseq_checker
  import ctxseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              xferValid,
  input logic              xferAck,
  input logic [XREG_W-1:0] xferReg,
  input logic [XCNT_W-1:0] xferCount,
  input logic              xferSave,
  input logic              ctxOpValid,
  input logic [SIZE_W-1:0] stateSize,
  input logic              busy,
  input logic              done,
  input logic              error
);
  p_xfer_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && !xferAck |=> xferValid && $stable(xferReg) && $stable(xferCount) && $stable(xferSave));

  p_xfer_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> busy);

  p_size_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(stateSize));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |=> error);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !busy && !xferValid && !ctxOpValid && !done);
endmodule

bind ctx_sequencer ctxseq_checker u_checker (
  .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferAck(xferAck),
  .xferReg(xferReg), .xferCount(xferCount), .xferSave(xferSave),
  .ctxOpValid(ctxOpValid), .stateSize(stateSize), .busy(busy),
  .done(done), .error(error)
);

// File: tb/test_ctx_sequencer.sv
module test_ctx_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progWe = 1'b0;
  logic [7:0] progAddr = '0;
  logic [23:0] progData = '0;
  logic start = 1'b0, hostSaveReq = 1'b0, hostLoadReq = 1'b0;
  logic autoSave = 1'b0, autoLoad = 1'b0, gfxBusy = 1'b0;
  logic xferAck = 1'b0;
  logic xferValid, xferSave, ctxOpValid, busy, done, error;
  logic [13:0] xferReg;
  logic [5:0] xferCount;
  logic [7:0] ctxOpCode;
  logic [19:0] stateSize;

  ctx_sequencer i_ctx_sequencer (.*);

  always #4 clk = ~clk;

  int testCnt = 0, failCnt = 0, cycles = 0;
  int xferCnt = 0, opCnt = 0, doneCnt = 0;
  logic [13:0] lastReg = '0;
  logic [5:0] lastCnt = '0;
  logic lastDir = 1'b0, autoAck = 1'b1;
  logic [7:0] lastOp = '0, prevOp = '0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cycles);
      summary();
      $finish;
    end
  end

  // Transfer mover and event log, all on the falling edge.
  always @(negedge clk) begin
    if (xferValid && autoAck && !xferAck) begin
      xferAck <= 1'b1;
      xferCnt++;
      lastReg = xferReg; lastCnt = xferCount; lastDir = xferSave;
    end else begin
      xferAck <= 1'b0;
    end
    if (ctxOpValid) begin opCnt++; prevOp = lastOp; lastOp = ctxOpCode; end
    if (done) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] eBra(input int tgt, input bit clr, input int f);
    return {4'h4, 4'h0, tgt[7:0], clr, f[6:0]};
  endfunction
  function automatic logic [23:0] eWait(input bit v, input int f);
    return {4'h5, 12'h0, v, f[6:0]};
  endfunction
  function automatic logic [23:0] eSet(input bit v, input int f);
    return {4'h7, 12'h0, v, f[6:0]};
  endfunction
  function automatic logic [23:0] eXfer(input int cnt, input int r);
    return {4'h1, cnt[5:0], r[13:0]};
  endfunction
  function automatic logic [23:0] eSize(input int v);
    return {4'h2, v[19:0]};
  endfunction
  function automatic logic [23:0] eMisc(input int c);
    return {4'h6, 12'h0, c[7:0]};
  endfunction

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    progWe = 1'b1; progAddr = a[7:0]; progData = d;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, "R2 program terminates", n, 2000);
    @(negedge clk);
  endtask

  task automatic hostPulse(input bit s, input bit l);
    @(negedge clk); hostSaveReq = s; hostLoadReq = l;
    @(negedge clk); hostSaveReq = 1'b0; hostLoadReq = 1'b0;
  endtask

  task automatic loadMain();
    wr(0, eBra(6, 0, 100));
    wr(1, eBra(6, 0, 5));
    wr(2, eBra(9, 0, 101));
    wr(3, eBra(9, 0, 6));
    wr(4, eBra(14, 0, 104));
    wr(5, eMisc(8'h55));
    wr(6, eSet(1, 0));
    wr(7, eXfer(5, 14'h123));
    wr(8, eBra(14, 0, 104));
    wr(9, eWait(0, 96));
    wr(10, eSet(0, 0));
    wr(11, eXfer(2, 14'h040));
    wr(12, eMisc(8'h09));
    wr(13, eBra(14, 0, 104));
    wr(14, eSet(0, 5));
    wr(15, eSet(0, 6));
    wr(16, eMisc(8'h0e));
  endtask

  typedef struct packed {
    logic hs, hl, as, al;
    logic expX, expDir, expOp;
    logic [13:0] xreg;
    logic [5:0] cnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 14'h000, 6'd0},
    '{1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0, 14'h123, 6'd5},
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 14'h040, 6'd2},
    '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 14'h123, 6'd5},
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 14'h040, 6'd2},
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0, 14'h123, 6'd5},
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 14'h000, 6'd0},
    '{1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 14'h040, 6'd2}
  };

  initial begin
    int bx, bo, bd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error, "R1 status idle after reset", {busy, done, error}, 0);
    chk(!xferValid && !ctxOpValid, "R1 no commands after reset", {xferValid, ctxOpValid}, 0);
    chk(stateSize == 0, "R1 size register cleared", stateSize, 0);
    rstN = 1'b1;
    loadMain();

    // Table: request pattern versus path taken (R2, R3, R7, R8, R9, R10)
    for (int i = 0; i < NV; i++) begin
      bx = xferCnt; bo = opCnt; bd = doneCnt;
      autoSave = VEC[i].as; autoLoad = VEC[i].al;
      if (VEC[i].hs || VEC[i].hl) hostPulse(VEC[i].hs, VEC[i].hl);
      pulseStart();
      waitIdle();
      autoSave = 1'b0; autoLoad = 1'b0;
      chk(xferCnt - bx == int'(VEC[i].expX), "R10 request selects transfer path", xferCnt - bx, VEC[i].expX);
      if (VEC[i].expX) begin
        chk(lastReg == VEC[i].xreg, "R7 transfer register field", lastReg, VEC[i].xreg);
        chk(lastCnt == VEC[i].cnt, "R7 transfer count field", lastCnt, VEC[i].cnt);
        chk(lastDir == VEC[i].expDir, "R7 direction from flag 0", lastDir, VEC[i].expDir);
      end
      chk(opCnt - bo == int'(VEC[i].expOp), "R8 context op count", opCnt - bo, VEC[i].expOp);
      if (VEC[i].expOp) chk(lastOp == 8'h09, "R8 context op code", lastOp, 8'h09);
      chk(doneCnt - bd == 1, "R9 one done pulse per run", doneCnt - bd, 1);
    end

    // R4 wait holds while engine busy
    bx = xferCnt;
    gfxBusy = 1'b1;
    hostPulse(0, 1);
    pulseStart();
    repeat (20) @(negedge clk);
    chk(busy, "R4 still running while stalled", busy, 1);
    chk(xferCnt == bx, "R4 no transfer before flag matches", xferCnt - bx, 0);
    gfxBusy = 1'b0;
    waitIdle();
    chk(xferCnt - bx == 1, "R4 proceeds after flag matches", xferCnt - bx, 1);

    // R7 command held without acknowledge
    autoAck = 1'b0;
    bd = doneCnt;
    hostPulse(1, 0);
    pulseStart();
    repeat (10) @(negedge clk);
    chk(xferValid && busy, "R7 command pending without ack", {xferValid, busy}, 3);
    chk(xferReg == 14'h123 && xferCount == 6'd5 && xferSave, "R7 held command fields",
        {xferSave, xferCount, xferReg}, {1'b1, 6'd5, 14'h123});
    chk(doneCnt == bd, "R7 no advance before ack", doneCnt - bd, 0);
    autoAck = 1'b1;
    waitIdle();
    chk(doneCnt - bd == 1, "R7 completes after ack", doneCnt - bd, 1);

    // R5 protected flags ignore writes, R3 branch-if-clear on constant flag
    wr(0, eSet(0, 104));
    wr(1, eSet(1, 96));
    wr(2, eSet(1, 100));
    wr(3, eSet(1, 101));
    wr(4, eBra(10, 0, 96));
    wr(5, eBra(10, 0, 100));
    wr(6, eBra(10, 0, 101));
    wr(7, eBra(10, 1, 104));
    wr(8, eMisc(8'h0a));
    wr(9, eMisc(8'h0e));
    wr(10, eMisc(8'h07));
    wr(11, eMisc(8'h0e));
    bo = opCnt;
    pulseStart();
    waitIdle();
    chk(opCnt - bo == 1 && lastOp == 8'h0a, "R5 protected flag writes ignored", lastOp, 8'h0a);

    // R3 both polarities on writable flag, R6 size load, R8 back-to-back ops
    wr(0, eBra(3, 1, 20));
    wr(1, eMisc(8'h07));
    wr(2, eMisc(8'h0e));
    wr(3, eSize(20'hABCDE));
    wr(4, eSet(1, 20));
    wr(5, eBra(7, 0, 20));
    wr(6, eMisc(8'h07));
    wr(7, eMisc(8'h09));
    wr(8, eMisc(8'h0a));
    wr(9, eMisc(8'h0e));
    bo = opCnt;
    pulseStart();
    waitIdle();
    chk(opCnt - bo == 2, "R3 branch polarity path", opCnt - bo, 2);
    chk(prevOp == 8'h09 && lastOp == 8'h0a, "R8 consecutive op codes", {prevOp, lastOp}, 16'h090a);
    chk(stateSize == 20'hABCDE, "R6 size register loaded", stateSize, 20'hABCDE);

    // R11 illegal opcode halts and is sticky
    bd = doneCnt;
    wr(0, 24'h300000);
    pulseStart();
    repeat (2) @(negedge clk);
    chk(error && !busy, "R11 illegal opcode halts", {error, busy}, 2);
    chk(doneCnt == bd, "R11 no done on halt", doneCnt - bd, 0);
    pulseStart();
    repeat (3) @(negedge clk);
    chk(!busy && error, "R11 start ignored while halted", {error, busy}, 2);

    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!error && !busy, "R1 reset clears error", {error, busy}, 0);
    rstN = 1'b1;
    wr(0, eMisc(8'h55));
    pulseStart();
    repeat (2) @(negedge clk);
    chk(error && !busy, "R11 unknown sub-operation halts", {error, busy}, 2);

    summary();
    $finish;
  end
endmodule